// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This block produces a periodic interrupt for a real-time-clock peripheral. The block runs on the system clock. A slow crystal-rate enable advances it, with one single-cycle pulse on `xtal_en` per crystal period. Software programs one control register through a simple write strobe. The low `CNT_W` bits of the register hold a count, and the top bit switches the timer on. While the timer is on, the block counts crystal pulses and raises a one-cycle interrupt once every count+1 pulses. It then reloads on its own.

A write that sets the top bit restarts the countdown from the new count, so software can realign the tick phase at any time. A write that clears the top bit halts the countdown at once. Any expiry that was about to happen is dropped. The register reads back exactly as last written.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset the register reads 0x00, `tick_irq` is low, and crystal pulses raise no interrupt.
- R2: `rd_data` returns the full value last written, including the enable bit (bit `CNT_W`), from the cycle after the write.
- R3: With enable set and count field N (bits `CNT_W-1:0`), the first interrupt comes on the (N+1)th crystal pulse after the write. `tick_irq` is high in the system cycle right after the clock edge that samples that pulse.
- R4: After each expiry the countdown reloads from N, so later interrupts follow every N+1 crystal pulses with no gap and no extra pulse.
- R5: While the enable bit is clear, no interrupt is raised. A write that clears the enable bit stops the countdown at once and drops an expiry that was due on the next pulse.
- R6: A write with the enable bit set restarts the countdown from the new count, even in mid-period. The next interrupt then comes N+1 crystal pulses after the write.
- R7: `tick_irq` is high only in a cycle that follows a clock edge where `xtal_en` was sampled high with no write. Between separated crystal pulses it is a single-cycle pulse.
- R8: When a write and a crystal pulse arrive on the same clock edge, the write takes effect, the pulse is not counted, and no interrupt is raised on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xtal_en | input | 1 | One-cycle pulse per crystal period |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | CNT_W+1 | Write data: enable in the top bit, count below it |
| rd_data | output | CNT_W+1 | Current register value |
| tick_irq | output | 1 | One-cycle tick interrupt |

## Verification
The bench builds the block with the default `CNT_W` of 7. At that width the whole count range from 0 to 127 can be swept. For every count it checks two full periods, which covers both the first expiry and the automatic reload, including the period-of-one case and the longest period. The bench steps each crystal pulse by hand, so it can land writes on exact pulse positions. This brings within reach the mid-period restart, a disable one pulse before expiry, and a write that collides with a crystal pulse.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_en,
  input  logic             wr_en,
  input  logic [CNT_W:0]   wr_data,
  output logic [CNT_W:0]   rd_data,
  output logic             tick_irq
);
  localparam int REG_W = CNT_W + 1;

  logic [REG_W-1:0] tick_reg;
  logic [CNT_W-1:0] remain;

  wire             run    = tick_reg[CNT_W];
  wire [CNT_W-1:0] period = tick_reg[CNT_W-1:0];
  wire             expire = run & xtal_en & ~wr_en & (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_reg <= '0;
      remain   <= '0;
      tick_irq <= 1'b0;
    end else begin
      tick_irq <= expire;
      if (wr_en) begin
        tick_reg <= wr_data;
        remain   <= wr_data[CNT_W-1:0];
      end else if (run && xtal_en) begin
        remain <= expire ? period : remain - 1'b1;
      end
    end
  end

  assign rd_data = tick_reg;

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && !tick_irq));

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst)) |-> rd_data == $past(wr_data));

  assert_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> remain <= period);

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> ($past(remain) == '0 && remain == period));

  assert_off_R5: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> $past(run));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_data[CNT_W]) && !$past(rst)) |-> remain == $past(wr_data[CNT_W-1:0]));

  assert_source_R7_R8: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> $past(xtal_en && !wr_en));
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam int CNT_W = 7;
  logic clk = 0, rst = 1, xtal_en = 0, wr_en = 0;
  logic [CNT_W:0] wr_data = '0;
  logic [CNT_W:0] rd_data;
  logic tick_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W)) u_tick_timer (
    .clk(clk), .rst(rst), .xtal_en(xtal_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick_irq(tick_irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_reg(input logic [CNT_W:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
    check("R2 readback", rd_data, v);
    check("R8 no irq on write", tick_irq, 0);
  endtask

  task automatic step(input string req, input bit exp);
    @(negedge clk); xtal_en = 1;
    @(posedge clk);
    @(negedge clk); xtal_en = 0;
    check(req, tick_irq, exp);
    @(posedge clk);
    @(negedge clk);
    check("R7 single cycle", tick_irq, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset irq", tick_irq, 0);
    for (int k = 0; k < 4; k++) step("R1 disabled after reset", 0);

    for (int c = 0; c < 128; c++) begin
      write_reg({1'b1, c[CNT_W-1:0]});
      for (int k = 1; k <= 2 * (c + 1); k++)
        step(k <= c + 1 ? "R3 first period" : "R4 reload period", (k % (c + 1)) == 0);
    end

    write_reg({1'b1, 7'd9});
    for (int k = 0; k < 5; k++) step("R6 before rewrite", 0);
    write_reg({1'b1, 7'd9});
    for (int k = 0; k < 9; k++) step("R6 after rewrite", 0);
    step("R6 full period after rewrite", 1);
    for (int k = 0; k < 4; k++) step("R6 partial", 0);
    write_reg({1'b1, 7'd3});
    for (int k = 0; k < 3; k++) step("R6 new count", 0);
    step("R6 new count expiry", 1);

    write_reg({1'b1, 7'd4});
    for (int k = 0; k < 4; k++) step("R5 pre-disable", 0);
    write_reg({1'b0, 7'd4});
    for (int k = 0; k < 10; k++) step("R5 disabled", 0);
    write_reg({1'b1, 7'd0});
    step("R5 count0 runs", 1);
    write_reg({1'b0, 7'd0});
    step("R5 pending dropped", 0);

    write_reg({1'b1, 7'd2});
    step("R8 setup", 0);
    step("R8 setup", 0);
    @(negedge clk); wr_en = 1; wr_data = {1'b1, 7'd2}; xtal_en = 1;
    @(posedge clk);
    @(negedge clk); wr_en = 0; xtal_en = 0;
    check("R8 collision no irq", tick_irq, 0);
    step("R8 after collision", 0);
    step("R8 after collision", 0);
    step("R8 expiry after collision", 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule